// File: doc/BRIEF.md
# Banked Scratchpad Conflict Arbiter

This block fronts an on-chip scratchpad built from 16 word-wide banks and lets a group of up to 16 lanes access it together. Each lane offers an active bit, a read/write bit, a word address and 32 bits of write data. A group is captured in one cycle. The block then serves it over as many cycles as the worst bank conflict requires. In each cycle every bank serves one distinct word. All pending lanes that name that word are served together, so reads of the same word share one read and writes to the same word collapse into one store.

Words are interleaved across banks by the low four bits of the word address, which is the byte address divided by four. The remaining bits select one of 64 rows inside the bank. Any lane may use any bank. Inside a bank, the lowest-numbered pending lane decides which word is served next. A `busy` output holds off new groups until every lane of the current one has been served. A `group_done` pulse marks the cycle in which the last lane is served.

Top module: `sp_bank_arbiter`

## Requirements
- R1: Word address bits [3:0] select the bank and bits [9:4] select the row. Two words in different rows of one bank stay distinct, and words in different banks are served in the same cycle.
- R2: A group is captured at a rising edge where `req_valid` is high, `busy` is low and at least one `req_active` bit is set. A group offered while `busy` is high is ignored and nothing of it is stored.
- R3: In any cycle a bank serves lanes of only one word address, and every active lane is served exactly once per group.
- R4: When lanes of one bank name different words, the word of the lowest-numbered pending lane in that bank is served first.
- R5: A group keeps `busy` high for exactly as many cycles as the largest number of distinct word addresses that fall into any one bank. There is always at least one lane served per busy cycle.
- R6: All lanes reading the same word are served in one cycle and receive the same data.
- R7: When several lanes write the same word in one group, the data of the highest-numbered of them is stored.
- R8: A lane reading a word that other lanes of the same group write receives the value held before the group.
- R9: `lane_served[i]` is high in each cycle in which lane i is served. `group_done` is high in exactly one cycle per group, the one in which the last pending lane is served, and `busy` is low in the following cycle.
- R10: `lane_rdata` for a reading lane takes the read word at the edge ending its service cycle and holds it until that lane's next read. A writing lane's read data does not change.
- R11: Inactive lanes are never served and their read data does not change. A group with no active lane leaves `busy` low.
- R12: After reset `busy`, `lane_served`, `group_done` and all of `lane_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Offers the lane inputs as a new group |
| req_active | input | 16 | Per-lane active bit |
| req_write | input | 16 | Per-lane write (1) or read (0) |
| req_waddr | input | 160 | Per-lane word address, lane i at bits [10i+9:10i] |
| req_wdata | input | 512 | Per-lane write data, lane i at bits [32i+31:32i] |
| busy | output | 1 | Lanes of the current group are still pending |
| lane_served | output | 16 | Per-lane pulse in the cycle the lane is served |
| group_done | output | 1 | Pulse in the cycle the last pending lane is served |
| lane_rdata | output | 512 | Per-lane held read data, lane i at bits [32i+31:32i] |

## Verification
Each cycle the assertions check the following. A served lane is always pending, and the lanes served in one bank all share a single word. The lowest pending lane of every occupied bank is always among those served. Every busy cycle makes progress, the pending set never grows, and busy falls right after the done pulse. The bench scenarios cover the data itself: how words map to rows, broadcast read values, which writer wins, read-before-write values within a group, the exact length of a group for several strides and masks, and that a group offered while busy leaves the storage untouched.

// File: rtl/sp_pkg.sv
package sp_pkg;
    localparam int unsigned DEF_LANES = 16;
    localparam int unsigned DEF_BANKS = 16;
    localparam int unsigned DEF_ROWS  = 64;
    localparam int unsigned DEF_DW    = 32;

    // width of a word address that covers every bank and row
    function automatic int unsigned word_addr_bits(input int unsigned banks, input int unsigned rows);
        return $clog2(banks) + $clog2(rows);
    endfunction
endpackage

// File: rtl/sp_bank_pick.sv
// Chooses the word one bank serves this cycle and the lanes that share it.
module sp_bank_pick #(
    parameter int unsigned LANES    = 16,
    parameter int unsigned BANKS    = 16,
    parameter int unsigned WAW      = 10,
    parameter int unsigned DW       = 32,
    parameter int unsigned BANK_IDX = 0
) (
    input  logic [LANES-1:0]           pend,
    input  logic [LANES-1:0]           wr,
    input  logic [LANES-1:0][WAW-1:0]  addr,
    input  logic [LANES-1:0][DW-1:0]   wdata,
    output logic [LANES-1:0]           grant,
    output logic [WAW-$clog2(BANKS)-1:0] row,
    output logic                       we,
    output logic [DW-1:0]              wdat
);
    localparam int unsigned BW = $clog2(BANKS);
    localparam logic [BW-1:0] MY_BANK = BW'(BANK_IDX);

    logic           found;
    logic [WAW-1:0] win_addr;

    // lowest pending lane in this bank names the word
    always_comb begin
        found    = 1'b0;
        win_addr = '0;
        for (int i = 0; i < int'(LANES); i++) begin
            if (!found && pend[i] && addr[i][BW-1:0] == MY_BANK) begin
                found    = 1'b1;
                win_addr = addr[i];
            end
        end
    end

    // every pending lane on that word rides along; last writer wins
    always_comb begin
        we   = 1'b0;
        wdat = '0;
        for (int i = 0; i < int'(LANES); i++) begin
            grant[i] = found && pend[i] && (addr[i] == win_addr);
            if (grant[i] && wr[i]) begin
                we   = 1'b1;
                wdat = wdata[i];
            end
        end
    end

    assign row = win_addr[WAW-1:BW];
endmodule

// File: rtl/sp_bank_mem.sv
// One bank: register array, read before write on the same row.
module sp_bank_mem #(
    parameter int unsigned ROWS = 64,
    parameter int unsigned DW   = 32
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [$clog2(ROWS)-1:0] row,
    input  logic [DW-1:0]           wdata,
    output logic [DW-1:0]           rdata
);
    logic [DW-1:0] mem_q [ROWS];

    always_ff @(posedge clk) begin
        if (we) mem_q[row] <= wdata;
    end

    assign rdata = mem_q[row];
endmodule

// File: rtl/sp_bank_arbiter.sv
module sp_bank_arbiter
    import sp_pkg::*;
#(
    parameter int unsigned LANES = DEF_LANES,
    parameter int unsigned BANKS = DEF_BANKS,
    parameter int unsigned ROWS  = DEF_ROWS,
    parameter int unsigned DW    = DEF_DW,
    localparam int unsigned WAW  = word_addr_bits(BANKS, ROWS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [LANES-1:0]     req_active,
    input  logic [LANES-1:0]     req_write,
    input  logic [LANES*WAW-1:0] req_waddr,
    input  logic [LANES*DW-1:0]  req_wdata,
    output logic                 busy,
    output logic [LANES-1:0]     lane_served,
    output logic                 group_done,
    output logic [LANES*DW-1:0]  lane_rdata
);
    localparam int unsigned BW = $clog2(BANKS);
    localparam int unsigned RW = $clog2(ROWS);

    typedef struct packed {
        logic [LANES-1:0]          pend;
        logic [LANES-1:0]          wr;
        logic [LANES-1:0][WAW-1:0] addr;
        logic [LANES-1:0][DW-1:0]  wdata;
        logic [LANES-1:0][DW-1:0]  rdata;
    } state_t;

    state_t st_q, st_d;

    logic [LANES-1:0][WAW-1:0] in_addr;
    logic [LANES-1:0][DW-1:0]  in_wdata;
    assign in_addr  = req_waddr;
    assign in_wdata = req_wdata;

    logic [BANKS-1:0][LANES-1:0] bank_grant;
    logic [BANKS-1:0][RW-1:0]    bank_row;
    logic [BANKS-1:0]            bank_we;
    logic [BANKS-1:0][DW-1:0]    bank_wdat;
    logic [BANKS-1:0][DW-1:0]    bank_rd;
    logic [LANES-1:0]            grant_all;

    for (genvar b = 0; b < int'(BANKS); b++) begin : g_bank
        sp_bank_pick #(
            .LANES(LANES), .BANKS(BANKS), .WAW(WAW), .DW(DW), .BANK_IDX(b)
        ) u_pick (
            .pend  (st_q.pend),
            .wr    (st_q.wr),
            .addr  (st_q.addr),
            .wdata (st_q.wdata),
            .grant (bank_grant[b]),
            .row   (bank_row[b]),
            .we    (bank_we[b]),
            .wdat  (bank_wdat[b])
        );

        sp_bank_mem #(.ROWS(ROWS), .DW(DW)) u_mem (
            .clk   (clk),
            .we    (bank_we[b]),
            .row   (bank_row[b]),
            .wdata (bank_wdat[b]),
            .rdata (bank_rd[b])
        );
    end

    always_comb begin
        grant_all = '0;
        for (int b = 0; b < int'(BANKS); b++) grant_all |= bank_grant[b];
    end

    logic accept;

    always_comb begin
        st_d   = st_q;
        accept = req_valid && (st_q.pend == '0) && (req_active != '0);
        if (accept) begin
            st_d.pend  = req_active;
            st_d.wr    = req_write;
            st_d.addr  = in_addr;
            st_d.wdata = in_wdata;
        end else begin
            st_d.pend = st_q.pend & ~grant_all;
            for (int i = 0; i < int'(LANES); i++) begin
                if (grant_all[i] && !st_q.wr[i])
                    st_d.rdata[i] = bank_rd[st_q.addr[i][BW-1:0]];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy        = (st_q.pend != '0);
    assign lane_served = grant_all;
    assign group_done  = busy && ((st_q.pend & ~grant_all) == '0);
    assign lane_rdata  = st_q.rdata;

    // state taps for the bound checker
    logic [LANES-1:0]          pend_q;
    logic [LANES-1:0][WAW-1:0] addr_q;
    assign pend_q = st_q.pend;
    assign addr_q = st_q.addr;
endmodule

// File: rtl/sp_bank_arbiter_chk.sv
module sp_bank_arbiter_chk #(
    parameter int unsigned LANES = 16,
    parameter int unsigned BANKS = 16,
    parameter int unsigned WAW   = 10
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      req_valid,
    input logic [LANES-1:0]          req_active,
    input logic                      busy,
    input logic [LANES-1:0]          lane_served,
    input logic                      group_done,
    input logic [LANES-1:0]          pend_q,
    input logic [LANES-1:0][WAW-1:0] addr_q
);
    localparam int unsigned BW = $clog2(BANKS);

    logic mixed_words;
    logic low_skipped;

    always_comb begin
        mixed_words = 1'b0;
        for (int i = 0; i < int'(LANES); i++)
            for (int j = i + 1; j < int'(LANES); j++)
                if (lane_served[i] && lane_served[j] &&
                    addr_q[i][BW-1:0] == addr_q[j][BW-1:0] && addr_q[i] != addr_q[j])
                    mixed_words = 1'b1;
    end

    always_comb begin
        low_skipped = 1'b0;
        for (int i = 0; i < int'(LANES); i++) begin
            logic lower;
            lower = 1'b0;
            for (int j = 0; j < i; j++)
                if (pend_q[j] && addr_q[j][BW-1:0] == addr_q[i][BW-1:0]) lower = 1'b1;
            if (pend_q[i] && !lane_served[i] && !lower) low_skipped = 1'b1;
        end
    end

    assert_served_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_served & ~pend_q) == '0);

    assert_one_word_per_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mixed_words);

    assert_lowest_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !low_skipped);

    assert_progress_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (lane_served != '0));

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        group_done |=> !busy);

    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && (req_active != '0)) |=> busy);

    assert_no_new_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ((pend_q & ~$past(pend_q)) == '0));
endmodule

bind sp_bank_arbiter sp_bank_arbiter_chk #(
    .LANES(LANES), .BANKS(BANKS), .WAW(WAW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_active (req_active),
    .busy       (busy),
    .lane_served(lane_served),
    .group_done (group_done),
    .pend_q     (pend_q),
    .addr_q     (addr_q)
);

// File: tb/tb_sp_bank_arbiter.sv
`timescale 1ns/1ps
module tb_sp_bank_arbiter;
    localparam int L = 16, DW = 32, WAW = 10, WORDS = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [L-1:0] req_active = '0, req_write = '0;
    logic [L*WAW-1:0] req_waddr = '0;
    logic [L*DW-1:0] req_wdata = '0;
    logic busy, group_done;
    logic [L-1:0] lane_served;
    logic [L*DW-1:0] lane_rdata;

    always #2.5 clk = ~clk;

    sp_bank_arbiter dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_active(req_active),
        .req_write(req_write), .req_waddr(req_waddr), .req_wdata(req_wdata),
        .busy(busy), .lane_served(lane_served), .group_done(group_done),
        .lane_rdata(lane_rdata)
    );

    int errors = 0, checks = 0;
    logic [31:0] model [WORDS];
    logic [31:0] exp_rd [L];
    logic [31:0] prev_rd [L];
    int serve_cyc [L];
    int serve_cnt [L];
    int cyc_count, done_cnt, done_cycle;

    typedef struct packed {
        logic [9:0]  base;
        logic [9:0]  stride;
        logic [15:0] mask;
        logic [7:0]  exp_cyc;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{10'd0, 10'd1,  16'hFFFF, 8'd1},
        '{10'd3, 10'd2,  16'hFFFF, 8'd2},
        '{10'd0, 10'd16, 16'hFFFF, 8'd16},
        '{10'd5, 10'd0,  16'hFFFF, 8'd1},
        '{10'd1, 10'd4,  16'hFFFF, 8'd4},
        '{10'd7, 10'd17, 16'hFFFF, 8'd1},
        '{10'd0, 10'd16, 16'h00FF, 8'd8},
        '{10'd2, 10'd8,  16'h0F0F, 8'd4},
        '{10'd9, 10'd0,  16'h0000, 8'd0}
    };

    function automatic logic [31:0] pat(input int a);
        return (32'(a) * 32'h9E3779B1) ^ 32'h5A5A0000;
    endfunction

    function automatic logic [31:0] rd(input int i);
        return lane_rdata[i*DW +: DW];
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic clear_lanes();
        req_active = '0; req_write = '0; req_waddr = '0; req_wdata = '0;
    endtask

    task automatic set_lane(input int i, input bit wr, input int a, input logic [31:0] d);
        req_active[i] = 1'b1;
        req_write[i]  = wr;
        req_waddr[i*WAW +: WAW] = WAW'(a);
        req_wdata[i*DW +: DW]   = d;
    endtask

    // launch the lanes as set, record service, update the reference model
    task automatic run_group();
        for (int i = 0; i < L; i++) begin
            serve_cyc[i] = 0; serve_cnt[i] = 0; prev_rd[i] = rd(i);
            if (req_active[i] && !req_write[i])
                exp_rd[i] = model[int'(req_waddr[i*WAW +: WAW])];
            else
                exp_rd[i] = prev_rd[i];
        end
        cyc_count = 0; done_cnt = 0; done_cycle = 0;
        @(negedge clk); req_valid = 1'b1;
        @(negedge clk); req_valid = 1'b0;
        while (busy && cyc_count < 200) begin
            cyc_count++;
            for (int i = 0; i < L; i++)
                if (lane_served[i]) begin serve_cnt[i]++; serve_cyc[i] = cyc_count; end
            if (group_done) begin done_cnt++; done_cycle = cyc_count; end
            @(negedge clk);
        end
        for (int i = 0; i < L; i++)
            if (req_active[i] && req_write[i])
                model[int'(req_waddr[i*WAW +: WAW])] = req_wdata[i*DW +: DW];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        summary();
    end

    initial begin
        bit pre_ok;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk(!busy && lane_served == '0 && !group_done, "R12", "control after reset",
            {29'd0, busy, group_done, |lane_served}, 32'd0);
        chk(lane_rdata == '0, "R12", "read data after reset", 32'(|lane_rdata), 32'd0);

        // preload every word, one bank-spread group per 16 words
        pre_ok = 1'b1;
        for (int g = 0; g < WORDS / L; g++) begin
            clear_lanes();
            for (int i = 0; i < L; i++) set_lane(i, 1'b1, g * L + i, pat(g * L + i));
            run_group();
            if (cyc_count != 1 || done_cnt != 1) pre_ok = 1'b0;
        end
        chk(pre_ok, "R3", "preload groups spread over banks took one cycle", 32'(pre_ok), 32'd1);

        // table of read patterns
        for (int v = 0; v < 9; v++) begin
            clear_lanes();
            for (int i = 0; i < L; i++)
                if (VECS[v].mask[i])
                    set_lane(i, 1'b0, (int'(VECS[v].base) + i * int'(VECS[v].stride)) % WORDS, '0);
            run_group();
            chk(cyc_count == int'(VECS[v].exp_cyc), "R5", $sformatf("vector %0d busy cycles", v),
                32'(cyc_count), 32'(VECS[v].exp_cyc));
            chk(done_cnt == (VECS[v].exp_cyc != 0 ? 1 : 0) && done_cycle == int'(VECS[v].exp_cyc),
                "R9", $sformatf("vector %0d done pulse cycle", v), 32'(done_cycle), 32'(VECS[v].exp_cyc));
            for (int i = 0; i < L; i++) begin
                if (VECS[v].mask[i]) begin
                    chk(serve_cnt[i] == 1, "R3", $sformatf("vector %0d lane %0d served once", v, i),
                        32'(serve_cnt[i]), 32'd1);
                    chk(rd(i) == exp_rd[i], VECS[v].stride == 0 ? "R6" : "R1",
                        $sformatf("vector %0d lane %0d read data", v, i), rd(i), exp_rd[i]);
                end else begin
                    chk(serve_cnt[i] == 0, "R11", $sformatf("vector %0d idle lane %0d served", v, i),
                        32'(serve_cnt[i]), 32'd0);
                    chk(rd(i) == prev_rd[i], "R10", $sformatf("vector %0d idle lane %0d data held", v, i),
                        rd(i), prev_rd[i]);
                end
            end
        end
        chk(!busy, "R11", "empty group leaves busy low", 32'(busy), 32'd0);

        // R1: rows within one bank, plus a second bank in parallel
        clear_lanes();
        set_lane(0, 1'b1, 0,  32'hA0000000);
        set_lane(1, 1'b1, 16, 32'hA0000001);
        set_lane(2, 1'b1, 32, 32'hA0000002);
        set_lane(3, 1'b1, 1,  32'hA0000003);
        run_group();
        chk(cyc_count == 3, "R1", "three rows of bank 0 take three cycles", 32'(cyc_count), 32'd3);
        chk(serve_cyc[3] == 1, "R1", "bank 1 lane served in first cycle", 32'(serve_cyc[3]), 32'd1);
        chk(rd(0) == exp_rd[0], "R10", "writing lane read data unchanged", rd(0), exp_rd[0]);
        clear_lanes();
        set_lane(5, 1'b0, 32, '0); set_lane(6, 1'b0, 0, '0);
        set_lane(7, 1'b0, 16, '0); set_lane(8, 1'b0, 1, '0);
        run_group();
        chk(rd(5) == 32'hA0000002, "R1", "row 2 read back", rd(5), 32'hA0000002);
        chk(rd(6) == 32'hA0000000, "R1", "row 0 read back", rd(6), 32'hA0000000);
        chk(rd(7) == 32'hA0000001, "R1", "row 1 read back", rd(7), 32'hA0000001);
        chk(rd(8) == 32'hA0000003, "R1", "bank 1 read back", rd(8), 32'hA0000003);

        // R4: lowest lane of a bank goes first
        clear_lanes();
        set_lane(5, 1'b0, 80, '0); set_lane(1, 1'b0, 16, '0);
        set_lane(3, 1'b0, 48, '0); set_lane(9, 1'b0, 2, '0);
        run_group();
        chk(serve_cyc[1] == 1, "R4", "lane 1 first", 32'(serve_cyc[1]), 32'd1);
        chk(serve_cyc[3] == 2, "R4", "lane 3 second", 32'(serve_cyc[3]), 32'd2);
        chk(serve_cyc[5] == 3, "R4", "lane 5 third", 32'(serve_cyc[5]), 32'd3);
        chk(serve_cyc[9] == 1, "R4", "other bank lane first", 32'(serve_cyc[9]), 32'd1);
        chk(rd(5) == pat(80), "R4", "lane 5 data", rd(5), pat(80));

        // R7 and R8: colliding writers and a reader of the same word
        clear_lanes();
        set_lane(2, 1'b1, 300, 32'h00000111);
        set_lane(7, 1'b1, 300, 32'h00000222);
        set_lane(11, 1'b1, 300, 32'h00000333);
        set_lane(4, 1'b0, 300, '0);
        run_group();
        chk(cyc_count == 1, "R7", "same-word writes in one cycle", 32'(cyc_count), 32'd1);
        chk(rd(4) == pat(300), "R8", "reader sees value before group", rd(4), pat(300));
        clear_lanes();
        set_lane(0, 1'b0, 300, '0);
        run_group();
        chk(rd(0) == 32'h00000333, "R7", "highest writer stored", rd(0), 32'h00000333);

        // R2: a group offered while busy is dropped
        clear_lanes();
        for (int i = 0; i < L; i++) set_lane(i, 1'b0, 3 + 16 * i, '0);
        @(negedge clk); req_valid = 1'b1;
        @(negedge clk); req_valid = 1'b0;
        clear_lanes();
        set_lane(0, 1'b1, 500, 32'hDEAD0000);
        req_valid = 1'b1;
        @(negedge clk); req_valid = 1'b0;
        n = 1;
        while (busy && n < 100) begin n++; @(negedge clk); end
        chk(n == 16, "R2", "busy length unaffected by offer while busy", 32'(n), 32'd16);
        repeat (2) @(negedge clk);
        chk(!busy, "R2", "dropped group not started later", 32'(busy), 32'd0);
        clear_lanes();
        set_lane(6, 1'b0, 500, '0);
        run_group();
        chk(rd(6) == pat(500), "R2", "word untouched by dropped write", rd(6), pat(500));

        summary();
    end
endmodule